// File: doc/BRIEF.md
# PCI Configuration Address/Data Port Unit

This block implements the two-port legacy mechanism for reaching PCI configuration space through I/O space. Byte offsets 0 to 3 of the unit hold a 32-bit address latch. Byte offsets 4 to 7 form a data window. Software first writes a target into the latch: the enable bit, bus, device, function and dword index. It then reads or writes the data window. The unit decodes the latch and forwards each permitted window access to a downstream configuration responder. That responder answers combinationally in the same cycle.

The unit also handles the edge cases of the port. It merges sub-word writes into the latch and enforces the access size and the 4-byte boundary. It raises a reset request when a single byte with bit 2 set is written at offset 1. It answers for slots that are not populated. It also patches two kinds of response: the memory-mapped configuration base, which it reports on behalf of the root host bridge, and the multifunction flag in the header-type dword of other devices.

An I/O access is a single-cycle strobe. Read data comes back registered, one cycle after the strobe.

Top module: `cfg_port_unit`

## Requirements
- R1: After reset the address latch reads as 0x00000000 and the reset-request output is low.
- R2: A latch write of 1 or 2 bytes replaces only the byte lanes starting at lane `offset`, and a 4-byte write at offset 0 replaces the whole latch. Write data is given little-endian, with its first byte in bits 7:0.
- R3: A latch write is ignored if its length is 3 or any value other than 1, 2 or 4, or if offset plus length exceeds 4.
- R4: A 1-byte write at offset 1 whose data bit 2 is set raises `rst_req` for exactly one cycle, in the cycle after the strobe, and leaves the latch unchanged.
- R5: A read returns the bytes from lane (offset mod 4) up to lane (offset mod 4 + length − 1) of the selected dword, packed into the low bits, with unused lanes zero. If that range crosses the 4-byte boundary, the result is 0xFFFFFFFF.
- R6: While latch bit 31 is clear, the data window reads as all-ones bytes and writes to it produce no downstream request.
- R7: The latch decodes as bus = bits 23:16, device = 15:11, function = 10:8 and dword index = 7:2. A window access forwards byte offset (offset − 4) and its length. A window write that crosses the dword boundary is dropped. Offsets 8 and above read 0xFFFFFFFF and ignore writes.
- R8: For target bus 0, device 0, function 0 with `ecam_en` high, dword index 24 reads as `ecam_base[31:0] | 1` and index 25 reads as `ecam_base[63:32]`. With `ecam_en` low, both indices read the responder's data.
- R9: For a non-root target, a window access goes out only if the slot's bit in `slot_present` (index bus·256 + device·8 + function) is set, and an absent target reads 0xFFFFFFFF. A header-type read (dword index 3) sets bit 23 if any function 1 to 7 of the same bus and device is present. The root target is never patched this way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_stb | input | 1 | One-cycle access strobe |
| io_we | input | 1 | 1 = write, 0 = read |
| io_off | input | 4 | Byte offset within the port |
| io_len | input | 3 | Access length in bytes |
| io_wdata | input | 32 | Write data, first byte in bits 7:0 |
| io_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| io_rdata | output | 32 | Read data |
| rst_req | output | 1 | One-cycle reset request pulse |
| ecam_en | input | 1 | Memory-mapped configuration base enabled |
| ecam_base | input | 64 | Memory-mapped configuration base address |
| slot_present | input | NBUS·256 | Presence bit per bus/device/function |
| cfg_req | output | 1 | Downstream request strobe |
| cfg_we | output | 1 | Downstream write |
| cfg_bus | output | 8 | Target bus |
| cfg_dev | output | 5 | Target device |
| cfg_fn | output | 3 | Target function |
| cfg_idx | output | 6 | Dword index |
| cfg_boff | output | 2 | Byte offset within the dword |
| cfg_len | output | 3 | Byte count |
| cfg_wdata | output | 32 | Write data |
| cfg_rdata | input | 32 | Responder read data, same cycle |

## Verification
The reset request and a latch read can occupy the same cycle. The bench writes the reset byte and drives a latch read in the very next cycle, so the read strobe coincides with the raised `rst_req`. It then judges three things: the pulse is seen high, the pulse is low again once the read data returns, and the returned latch value matches its value before the reset byte. That last check shows that the reset byte neither merged into lane 1 nor was lost behind the adjacent read.

// File: rtl/cfg_port_unit.sv
module cfg_port_unit #(
  parameter int NBUS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_stb,
  input  logic                  io_we,
  input  logic [3:0]            io_off,
  input  logic [2:0]            io_len,
  input  logic [31:0]           io_wdata,
  output logic                  io_rvalid,
  output logic [31:0]           io_rdata,
  output logic                  rst_req,
  input  logic                  ecam_en,
  input  logic [63:0]           ecam_base,
  input  logic [NBUS*256-1:0]   slot_present,
  output logic                  cfg_req,
  output logic                  cfg_we,
  output logic [7:0]            cfg_bus,
  output logic [4:0]            cfg_dev,
  output logic [2:0]            cfg_fn,
  output logic [5:0]            cfg_idx,
  output logic [1:0]            cfg_boff,
  output logic [2:0]            cfg_len,
  output logic [31:0]           cfg_wdata,
  input  logic [31:0]           cfg_rdata
);
  localparam int BW = $clog2(NBUS);
  localparam int HDR_IDX = 3;
  localparam logic [31:0] MF_BIT = 32'h0080_0000;

  logic [31:0] addr_q;
  logic        en, is_root, in_range, present, mf;
  logic        sel_lat, sel_win, fits, lat_len_ok, rst_hit, lat_wr;
  logic [1:0]  boff;
  logic [3:0]  span;
  logic [31:0] len_mask, lane_mask, win_val, sel_val;
  logic [BW+7:0] slot_idx, slot_base;

  assign en       = addr_q[31];
  assign cfg_bus  = addr_q[23:16];
  assign cfg_dev  = addr_q[15:11];
  assign cfg_fn   = addr_q[10:8];
  assign cfg_idx  = addr_q[7:2];
  assign is_root  = (cfg_bus == 8'd0) && (cfg_dev == 5'd0) && (cfg_fn == 3'd0);
  assign in_range = ({24'd0, cfg_bus} < NBUS);
  assign slot_idx  = {cfg_bus[BW-1:0], cfg_dev, cfg_fn};
  assign slot_base = {cfg_bus[BW-1:0], cfg_dev, 3'b000};
  assign present  = in_range && slot_present[slot_idx];
  assign mf       = in_range && (|(slot_present[slot_base +: 8] >> 1));

  assign boff    = io_off[1:0];
  assign sel_lat = (io_off[3:2] == 2'b00);
  assign sel_win = (io_off[3:2] == 2'b01);
  assign span    = {2'b00, boff} + {1'b0, io_len};
  assign fits    = (span <= 4'd4) && (io_len != 3'd0);

  always_comb begin
    case (io_len)
      3'd1:    len_mask = 32'h0000_00FF;
      3'd2:    len_mask = 32'h0000_FFFF;
      3'd3:    len_mask = 32'h00FF_FFFF;
      3'd4:    len_mask = 32'hFFFF_FFFF;
      default: len_mask = 32'h0000_0000;
    endcase
  end

  assign lat_len_ok = (io_len == 3'd1) || (io_len == 3'd2) || (io_len == 3'd4);
  assign rst_hit    = io_stb && io_we && (io_off == 4'd1) && (io_len == 3'd1) && io_wdata[2];
  assign lat_wr     = io_stb && io_we && sel_lat && !rst_hit && fits && lat_len_ok;
  assign lane_mask  = len_mask << {boff, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= rst_hit;
      if (lat_wr)
        addr_q <= (addr_q & ~lane_mask) | ((io_wdata << {boff, 3'b000}) & lane_mask);
    end
  end

  assign cfg_req   = io_stb && sel_win && en && (is_root || present) && (!io_we || fits);
  assign cfg_we    = io_we;
  assign cfg_boff  = boff;
  assign cfg_len   = io_len;
  assign cfg_wdata = io_wdata;

  always_comb begin
    if (!en)
      win_val = 32'hFFFF_FFFF;
    else if (is_root) begin
      if (ecam_en && cfg_idx == 6'd24)
        win_val = ecam_base[31:0] | 32'd1;
      else if (ecam_en && cfg_idx == 6'd25)
        win_val = ecam_base[63:32];
      else
        win_val = cfg_rdata;
    end else if (!present)
      win_val = 32'hFFFF_FFFF;
    else if (cfg_idx == 6'(HDR_IDX) && mf)
      win_val = cfg_rdata | MF_BIT;
    else
      win_val = cfg_rdata;
  end

  assign sel_val = sel_lat ? addr_q : (sel_win ? win_val : 32'hFFFF_FFFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
    end else begin
      io_rvalid <= io_stb && !io_we;
      if (io_stb && !io_we)
        io_rdata <= fits ? ((sel_val >> {boff, 3'b000}) & len_mask) : 32'hFFFF_FFFF;
    end
  end
endmodule

module cfg_port_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_stb,
  input logic        io_we,
  input logic [3:0]  io_off,
  input logic [2:0]  io_len,
  input logic [31:0] io_wdata,
  input logic        io_rvalid,
  input logic [31:0] io_rdata,
  input logic        rst_req,
  input logic        cfg_req,
  input logic [1:0]  cfg_boff,
  input logic [31:0] addr_q
);
  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (addr_q == 32'd0) && !rst_req);
  p_pulse_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(io_stb && io_we && io_off == 4'd1 && io_len == 3'd1 && io_wdata[2]));
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $stable(addr_q));
  p_rvalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |-> $past(io_stb && !io_we));
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> addr_q[31]);
  p_dis_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_stb && !io_we && io_off == 4'd4 && io_len == 3'd4 && !addr_q[31]) |=> io_rdata == 32'hFFFF_FFFF);
  p_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (io_off[3:2] == 2'b01) && (cfg_boff == io_off[1:0]));
endmodule

bind cfg_port_unit cfg_port_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_stb(io_stb), .io_we(io_we), .io_off(io_off),
  .io_len(io_len), .io_wdata(io_wdata), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
  .rst_req(rst_req), .cfg_req(cfg_req), .cfg_boff(cfg_boff), .addr_q(addr_q)
);

// File: tb/sim_cfg_port_unit.sv
module sim_cfg_port_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NBUS = 4;
  localparam int NV = 32;

  logic clk = 0, rst_n = 0;
  logic io_stb = 0, io_we = 0;
  logic [3:0] io_off = 0;
  logic [2:0] io_len = 0;
  logic [31:0] io_wdata = 0;
  logic io_rvalid, rst_req;
  logic [31:0] io_rdata;
  logic ecam_en = 1;
  logic [63:0] ecam_base = 64'h0000_0012_3456_0000;
  logic [NBUS*256-1:0] slot_present;
  logic cfg_req, cfg_we;
  logic [7:0] cfg_bus;
  logic [4:0] cfg_dev;
  logic [2:0] cfg_fn, cfg_len;
  logic [5:0] cfg_idx;
  logic [1:0] cfg_boff;
  logic [31:0] cfg_wdata, cfg_rdata;

  int n_chk = 0, n_fail = 0, wr_cnt = 0;
  logic [58:0] wr_cap;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_unit #(.NBUS(NBUS)) u0 (
    .clk(clk), .rst_n(rst_n), .io_stb(io_stb), .io_we(io_we), .io_off(io_off),
    .io_len(io_len), .io_wdata(io_wdata), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
    .rst_req(rst_req), .ecam_en(ecam_en), .ecam_base(ecam_base),
    .slot_present(slot_present), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_fn(cfg_fn), .cfg_idx(cfg_idx),
    .cfg_boff(cfg_boff), .cfg_len(cfg_len), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  // responder: {idx,00, bus, dev,fn, 5A}
  assign cfg_rdata = {cfg_idx, 2'b00, cfg_bus, cfg_dev, cfg_fn, 8'h5A};

  always @(posedge clk)
    if (cfg_req && cfg_we) begin
      wr_cnt <= wr_cnt + 1;
      wr_cap <= {cfg_bus, cfg_dev, cfg_fn, cfg_idx, cfg_boff, cfg_len, cfg_wdata};
    end

  // {we, off, len, data, expected, req}
  localparam logic [75:0] VEC [NV] = '{
    {1'b1, 4'd0, 3'd4, 32'h1122_3344, 32'h0,          4'd2}, // R2
    {1'b0, 4'd0, 3'd4, 32'h0,         32'h1122_3344,  4'd2}, // R2
    {1'b1, 4'd2, 3'd2, 32'h0000_55AA, 32'h0,          4'd2}, // R2
    {1'b0, 4'd0, 3'd4, 32'h0,         32'h55AA_3344,  4'd2}, // R2
    {1'b1, 4'd1, 3'd1, 32'h0000_0009, 32'h0,          4'd2}, // R2
    {1'b0, 4'd0, 3'd4, 32'h0,         32'h55AA_0944,  4'd2}, // R2
    {1'b0, 4'd2, 3'd2, 32'h0,         32'h0000_55AA,  4'd5}, // R5
    {1'b0, 4'd3, 3'd1, 32'h0,         32'h0000_0055,  4'd5}, // R5
    {1'b0, 4'd3, 3'd2, 32'h0,         32'hFFFF_FFFF,  4'd5}, // R5
    {1'b1, 4'd1, 3'd2, 32'h0000_BEEF, 32'h0,          4'd2}, // R2
    {1'b0, 4'd0, 3'd4, 32'h0,         32'h55BE_EF44,  4'd2}, // R2
    {1'b1, 4'd2, 3'd4, 32'h0,         32'h0,          4'd3}, // R3
    {1'b0, 4'd0, 3'd4, 32'h0,         32'h55BE_EF44,  4'd3}, // R3
    {1'b1, 4'd0, 3'd3, 32'h0,         32'h0,          4'd3}, // R3
    {1'b0, 4'd0, 3'd4, 32'h0,         32'h55BE_EF44,  4'd3}, // R3
    {1'b0, 4'd8, 3'd4, 32'h0,         32'hFFFF_FFFF,  4'd7}, // R7
    {1'b0, 4'd5, 3'd2, 32'h0,         32'h0000_FFFF,  4'd6}, // R6
    {1'b1, 4'd0, 3'd4, 32'h8001_1000, 32'h0,          4'd7}, // R7
    {1'b0, 4'd4, 3'd4, 32'h0,         32'h0001_105A,  4'd7}, // R7
    {1'b1, 4'd0, 3'd1, 32'h0000_000C, 32'h0,          4'd9}, // R9
    {1'b0, 4'd4, 3'd4, 32'h0,         32'h0C81_105A,  4'd9}, // R9
    {1'b0, 4'd6, 3'd1, 32'h0,         32'h0000_0081,  4'd7}, // R7
    {1'b1, 4'd1, 3'd1, 32'h0000_0020, 32'h0,          4'd9}, // R9
    {1'b0, 4'd4, 3'd4, 32'h0,         32'h0C01_205A,  4'd9}, // R9
    {1'b1, 4'd1, 3'd1, 32'h0000_0018, 32'h0,          4'd9}, // R9
    {1'b0, 4'd4, 3'd4, 32'h0,         32'hFFFF_FFFF,  4'd9}, // R9
    {1'b1, 4'd0, 3'd4, 32'h8000_0060, 32'h0,          4'd8}, // R8
    {1'b0, 4'd4, 3'd4, 32'h0,         32'h3456_0001,  4'd8}, // R8
    {1'b1, 4'd0, 3'd1, 32'h0000_0064, 32'h0,          4'd8}, // R8
    {1'b0, 4'd4, 3'd4, 32'h0,         32'h0000_0012,  4'd8}, // R8
    {1'b1, 4'd0, 3'd1, 32'h0000_000C, 32'h0,          4'd9}, // R9
    {1'b0, 4'd4, 3'd4, 32'h0,         32'h0C00_005A,  4'd9}  // R9
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the strobe cycle
  task automatic acc(input logic we, input logic [3:0] off, input logic [2:0] len, input logic [31:0] d);
    io_stb = 1; io_we = we; io_off = off; io_len = len; io_wdata = d;
    @(negedge clk);
    io_stb = 0; io_we = 0;
  endtask

  initial begin
    slot_present = '0;
    slot_present[272] = 1'b1;
    slot_present[275] = 1'b1;
    slot_present[288] = 1'b1;
    slot_present[1]   = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 rst_req", {63'd0, rst_req}, 64'd0);
    acc(0, 4'd0, 3'd4, 0);
    chk("R1 latch", {32'd0, io_rdata}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][75], VEC[i][74:71], VEC[i][70:68], VEC[i][67:36]);
      if (!VEC[i][75])
        chk($sformatf("R%0d vec%0d", VEC[i][3:0], i), {32'd0, io_rdata}, {32'd0, VEC[i][35:4]});
    end

    // R4: reset pulse overlapping the following latch read
    acc(1, 4'd1, 3'd1, 32'h0000_0004);
    chk("R4 pulse high", {63'd0, rst_req}, 64'd1);
    acc(0, 4'd0, 3'd4, 0);
    chk("R4 pulse low", {63'd0, rst_req}, 64'd0);
    chk("R4 latch kept", {32'd0, io_rdata}, {32'd0, 32'h8000_000C});

    // R7: window write forwarding
    acc(1, 4'd0, 3'd4, 32'h8001_1014);
    begin
      int c0;
      c0 = wr_cnt;
      acc(1, 4'd6, 3'd2, 32'h0000_ABCD);
      chk("R7 wr count", 64'(wr_cnt), 64'(c0 + 1));
      chk("R7 wr fields", {5'd0, wr_cap},
          {5'd0, 8'd1, 5'd2, 3'd0, 6'd5, 2'd2, 3'd2, 32'h0000_ABCD});
      acc(1, 4'd6, 3'd4, 32'h1);
      chk("R7 boundary drop", 64'(wr_cnt), 64'(c0 + 1));
      acc(1, 4'd9, 3'd1, 32'h5A);
      chk("R7 beyond drop", 64'(wr_cnt), 64'(c0 + 1));
      acc(0, 4'd0, 3'd4, 0);
      chk("R7 latch kept", {32'd0, io_rdata}, {32'd0, 32'h8001_1014});
      // R6: disabled write dropped
      acc(1, 4'd3, 3'd1, 32'h0);
      acc(1, 4'd4, 3'd4, 32'h1);
      chk("R6 no request", 64'(wr_cnt), 64'(c0 + 1));
      acc(0, 4'd0, 3'd4, 0);
      chk("R6 latch", {32'd0, io_rdata}, {32'd0, 32'h0001_1014});
      // R9: write to absent slot dropped
      acc(1, 4'd0, 3'd4, 32'h8001_1800);
      acc(1, 4'd4, 3'd4, 32'h1);
      chk("R9 absent write", 64'(wr_cnt), 64'(c0 + 1));
    end

    // R8: base not injected when disabled
    acc(1, 4'd0, 3'd4, 32'h8000_0060);
    ecam_en = 0;
    acc(0, 4'd4, 3'd4, 0);
    chk("R8 ecam off", {32'd0, io_rdata}, {32'd0, 32'h6000_005A});

    // R1: reset in mid-run
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    acc(0, 4'd0, 3'd4, 0);
    chk("R1 latch after reset", {32'd0, io_rdata}, 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule